// File: doc/BRIEF.md
# Memory-Type-Aware Coherence Line Controller

This block works out what happens to one cache line when the local processor reads or writes it. The request carries the line's present coherence state, the memory-type attribute of the address, the access direction and which cache level holds the line. One clock later the block answers with the line's next state and an invalidation flag. When the access needs the system bus, it also raises a single-cycle bus request and gives the kind of transaction.

The memory type decides three things: whether a miss allocates the line, whether a write hit keeps or drops the line, and whether the write reaches the bus. Writeback lines allocate on every miss and keep owned writes local. Write-through and write-protected lines send every write to the bus. At the second level, a write hit on either type drops the line. Uncacheable accesses never allocate, and they drop any copy they hit. A write to a Shared writeback line first needs ownership. The block issues an ownership request and waits in a busy state until the grant input arrives. It then reports the line as Modified.

The sequencer has two named states. `FS_IDLE` accepts requests. `FS_OWN_WAIT` waits for the ownership grant. The transition `FS_IDLE -> FS_OWN_WAIT` fires on a write to a Shared writeback line. The transition `FS_OWN_WAIT -> FS_IDLE` fires when `own_grant` is high. Every other request answers directly from `FS_IDLE` and stays there.

Top module: `mlc_line_ctrl`

## Requirements
- R1: During and just after reset, `rsp_valid`, `bus_req`, `rsp_inval` and `busy` are 0 and `bus_kind` is NONE (0).
- R2: The encodings are as follows. Line state: I=0, S=1, E=2, M=3. Memory type: UC=0, WT=1, WP=2, WB=3. Bus kind: NONE=0, READ_LINE=1, READ_PART=2, WRITE_PART=3, OWNERSHIP=4. Level: 0 is the first level and 1 the second. A read that hits (S, E or M) on WB, WT or WP answers one cycle later with the state unchanged, no bus request and no invalidation.
- R3: A read miss (state I) on WB, WT or WP answers with READ_LINE. The new state is S when `snoop_shared` is 1 and E when it is 0.
- R4: A WB write to E or M yields M with no bus request. A WB write to I yields M with a READ_LINE request.
- R5: A WB write to S raises `bus_req` with kind OWNERSHIP for exactly one cycle, with `busy` high and no response. One cycle after `own_grant` is seen, the block answers M with no invalidation, and `busy` falls.
- R6: A WT write always requests WRITE_PART. A first-level hit keeps the state. A second-level hit yields I with `rsp_inval`=1. A miss stays I with `rsp_inval`=0.
- R7: A WP write always requests WRITE_PART. It never yields a state other than the current one, except that a second-level hit yields I with `rsp_inval`=1. A miss stays I.
- R8: A UC read requests READ_PART and a UC write requests WRITE_PART. The new state is always I, at either level. `rsp_inval` is 1 exactly when the incoming state was not I.
- R9: A request presented while `busy` is high gets no response and no bus request. An `own_grant` pulse while idle produces no response.
- R10: `bus_req` is high exactly when `bus_kind` is not NONE, and `rsp_inval` is only high together with `rsp_valid` and a state of I.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_level | input | 1 | 0 = first-level cache, 1 = second-level cache |
| req_mtype | input | 2 | Memory type of the access |
| req_state | input | 2 | Current coherence state of the line |
| snoop_shared | input | 1 | Fill will be shared by another agent |
| own_grant | input | 1 | Ownership granted on the bus |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_state | output | 2 | Next coherence state, valid with `rsp_valid` |
| rsp_inval | output | 1 | Line copy is invalidated |
| bus_req | output | 1 | Bus request pulse |
| bus_kind | output | 3 | Kind of bus transaction |
| busy | output | 1 | Waiting for ownership grant |

## Verification
A corrupted sequencer state shows up in two ways. The block may stay busy after a grant, so `busy` stays high and later requests vanish without a response. Or it may drop back to idle too early, so `busy` falls without an M response. Either way the fault is visible on the cycle after the grant. A wrong policy decision shows on the first response after the faulty request. It appears as a wrong next state, a missing or extra invalidation, or a bus kind that disagrees with the memory type. The directed scenarios walk every memory type at both levels, so a fault in any one type branch has an observable case.

// File: rtl/mlc_pkg.sv
package mlc_pkg;

    localparam int STATE_W = 2;
    localparam int MTYPE_W = 2;
    localparam int KIND_W  = 3;

    typedef enum logic [STATE_W-1:0] {
        LN_I = 2'd0,
        LN_S = 2'd1,
        LN_E = 2'd2,
        LN_M = 2'd3
    } line_state_e;

    typedef enum logic [MTYPE_W-1:0] {
        MT_UC = 2'd0,
        MT_WT = 2'd1,
        MT_WP = 2'd2,
        MT_WB = 2'd3
    } mem_type_e;

    typedef enum logic [KIND_W-1:0] {
        BK_NONE       = 3'd0,
        BK_READ_LINE  = 3'd1,
        BK_READ_PART  = 3'd2,
        BK_WRITE_PART = 3'd3,
        BK_OWNERSHIP  = 3'd4
    } bus_kind_e;

    typedef struct packed {
        line_state_e next;
        bus_kind_e   kind;
        logic        inval;
        logic        need_grant;
    } decision_t;

endpackage

// File: rtl/mlc_policy.sv
module mlc_policy
    import mlc_pkg::*;
(
    input  logic        is_write,
    input  logic        level_second,
    input  mem_type_e   mtype,
    input  line_state_e cur,
    input  logic        shared_fill,
    output decision_t   dec
);

    logic        hit;
    line_state_e fill_state;

    assign hit        = (cur != LN_I);
    assign fill_state = shared_fill ? LN_S : LN_E;

    always_comb begin
        dec.next       = cur;
        dec.kind       = BK_NONE;
        dec.inval      = 1'b0;
        dec.need_grant = 1'b0;
        unique case (mtype)
            MT_UC: begin
                // never cached: any hit drops the entry at either level
                dec.next  = LN_I;
                dec.inval = hit;
                dec.kind  = is_write ? BK_WRITE_PART : BK_READ_PART;
            end
            MT_WB: begin
                if (!is_write) begin
                    if (!hit) begin
                        dec.next = fill_state;
                        dec.kind = BK_READ_LINE;
                    end
                end else begin
                    unique case (cur)
                        LN_I: begin
                            dec.next = LN_M;
                            dec.kind = BK_READ_LINE;
                        end
                        LN_S: begin
                            dec.next       = LN_M;
                            dec.kind       = BK_OWNERSHIP;
                            dec.need_grant = 1'b1;
                        end
                        LN_E, LN_M: begin
                            dec.next = LN_M;
                        end
                    endcase
                end
            end
            MT_WT, MT_WP: begin
                if (!is_write) begin
                    if (!hit) begin
                        dec.next = fill_state;
                        dec.kind = BK_READ_LINE;
                    end
                end else begin
                    // writes always go out; no allocation on a miss.
                    // WT first-level hit updates data in place, WP leaves
                    // it untouched: the state is kept in both cases.
                    dec.kind = BK_WRITE_PART;
                    if (hit && level_second) begin
                        dec.next  = LN_I;
                        dec.inval = 1'b1;
                    end
                end
            end
        endcase
    end

endmodule

// File: rtl/mlc_fsm.sv
module mlc_fsm
    import mlc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  decision_t   dec,
    input  logic        own_grant,
    output logic        rsp_valid,
    output line_state_e rsp_state,
    output logic        rsp_inval,
    output logic        bus_req,
    output bus_kind_e   bus_kind,
    output logic        busy
);

    typedef enum logic {
        FS_IDLE     = 1'b0,
        FS_OWN_WAIT = 1'b1
    } fsm_e;

    fsm_e cur_q, nxt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= FS_IDLE;
        else        cur_q <= nxt;
    end

    always_comb begin
        nxt = cur_q;
        unique case (cur_q)
            FS_IDLE:     if (req_valid && dec.need_grant) nxt = FS_OWN_WAIT;
            FS_OWN_WAIT: if (own_grant) nxt = FS_IDLE;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_state <= LN_I;
            rsp_inval <= 1'b0;
            bus_req   <= 1'b0;
            bus_kind  <= BK_NONE;
            busy      <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_inval <= 1'b0;
            bus_req   <= 1'b0;
            bus_kind  <= BK_NONE;
            busy      <= (nxt == FS_OWN_WAIT);
            unique case (cur_q)
                FS_IDLE: begin
                    if (req_valid) begin
                        if (dec.need_grant) begin
                            bus_req  <= 1'b1;
                            bus_kind <= BK_OWNERSHIP;
                        end else begin
                            rsp_valid <= 1'b1;
                            rsp_state <= dec.next;
                            rsp_inval <= dec.inval;
                            bus_req   <= (dec.kind != BK_NONE);
                            bus_kind  <= dec.kind;
                        end
                    end
                end
                FS_OWN_WAIT: begin
                    if (own_grant) begin
                        rsp_valid <= 1'b1;
                        rsp_state <= LN_M;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/mlc_line_ctrl.sv
module mlc_line_ctrl
    import mlc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_write,
    input  logic       req_level,
    input  logic [1:0] req_mtype,
    input  logic [1:0] req_state,
    input  logic       snoop_shared,
    input  logic       own_grant,
    output logic       rsp_valid,
    output logic [1:0] rsp_state,
    output logic       rsp_inval,
    output logic       bus_req,
    output logic [2:0] bus_kind,
    output logic       busy
);

    decision_t   dec;
    line_state_e st_out;
    bus_kind_e   kind_out;

    mlc_policy i_policy (
        .is_write     (req_write),
        .level_second (req_level),
        .mtype        (mem_type_e'(req_mtype)),
        .cur          (line_state_e'(req_state)),
        .shared_fill  (snoop_shared),
        .dec          (dec)
    );

    mlc_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .dec       (dec),
        .own_grant (own_grant),
        .rsp_valid (rsp_valid),
        .rsp_state (st_out),
        .rsp_inval (rsp_inval),
        .bus_req   (bus_req),
        .bus_kind  (kind_out),
        .busy      (busy)
    );

    assign rsp_state = st_out;
    assign bus_kind  = kind_out;

endmodule

// File: rtl/mlc_checker.sv
module mlc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [1:0] req_mtype,
    input logic       rsp_valid,
    input logic [1:0] rsp_state,
    input logic       rsp_inval,
    input logic       bus_req,
    input logic [2:0] bus_kind,
    input logic       busy
);

    p_req_kind_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req == (bus_kind != 3'd0));

    p_inval_only_i_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_inval |-> (rsp_valid && rsp_state == 2'd0));

    p_busy_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !rsp_valid);

    p_own_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> !bus_req);

    p_grant_m_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (rsp_valid && rsp_state == 2'd3 && !rsp_inval));

    p_uc_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_mtype == 2'd0) |=> (rsp_valid && rsp_state == 2'd0));

endmodule

bind mlc_line_ctrl mlc_checker i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_mtype (req_mtype),
    .rsp_valid (rsp_valid),
    .rsp_state (rsp_state),
    .rsp_inval (rsp_inval),
    .bus_req   (bus_req),
    .bus_kind  (bus_kind),
    .busy      (busy)
);

// File: tb/test_mlc_line_ctrl.sv
module test_mlc_line_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic       req_level = 1'b0;
    logic [1:0] req_mtype = 2'd0;
    logic [1:0] req_state = 2'd0;
    logic       snoop_shared = 1'b0;
    logic       own_grant = 1'b0;
    logic       rsp_valid;
    logic [1:0] rsp_state;
    logic       rsp_inval;
    logic       bus_req;
    logic [2:0] bus_kind;
    logic       busy;

    int checks = 0;
    int fails  = 0;

    localparam logic [1:0] I = 2'd0, S = 2'd1, E = 2'd2, M = 2'd3;
    localparam logic [1:0] UC = 2'd0, WT = 2'd1, WP = 2'd2, WB = 2'd3;
    localparam logic [2:0] K_NONE = 3'd0, K_RL = 3'd1, K_RP = 3'd2, K_WP = 3'd3, K_OWN = 3'd4;

    always #2.5 clk = ~clk;

    mlc_line_ctrl i_mlc_line_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_level(req_level), .req_mtype(req_mtype), .req_state(req_state),
        .snoop_shared(snoop_shared), .own_grant(own_grant), .rsp_valid(rsp_valid),
        .rsp_state(rsp_state), .rsp_inval(rsp_inval), .bus_req(bus_req),
        .bus_kind(bus_kind), .busy(busy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one request, checks the registered answer one cycle later
    task automatic access(input string tag, input logic wr, input logic lvl,
                          input logic [1:0] mt, input logic [1:0] st, input logic sh,
                          input logic [1:0] exp_st, input logic [2:0] exp_kind,
                          input logic exp_inv);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_level = lvl;
        req_mtype = mt; req_state = st; snoop_shared = sh;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " valid"}, rsp_valid, 1);
        chk({tag, " state"}, rsp_state, exp_st);
        chk({tag, " kind"},  bus_kind, exp_kind);
        chk({tag, " req"},   bus_req, exp_kind != K_NONE);
        chk({tag, " inval"}, rsp_inval, exp_inv);
    endtask

    task automatic t_reset;
        chk("R1 rsp_valid", rsp_valid, 0);
        chk("R1 bus_req", bus_req, 0);
        chk("R1 kind", bus_kind, K_NONE);
        chk("R1 busy", busy, 0);
        chk("R1 inval", rsp_inval, 0);
    endtask

    task automatic t_read_hits;
        access("R2 wb S rd", 0, 0, WB, S, 0, S, K_NONE, 0);
        access("R2 wb E rd", 0, 1, WB, E, 1, E, K_NONE, 0);
        access("R2 wt M rd", 0, 1, WT, M, 0, M, K_NONE, 0);
        access("R2 wp S rd", 0, 0, WP, S, 0, S, K_NONE, 0);
    endtask

    task automatic t_read_miss;
        access("R3 wb excl", 0, 0, WB, I, 0, E, K_RL, 0);
        access("R3 wb shrd", 0, 1, WB, I, 1, S, K_RL, 0);
        access("R3 wt shrd", 0, 0, WT, I, 1, S, K_RL, 0);
        access("R3 wp excl", 0, 1, WP, I, 0, E, K_RL, 0);
    endtask

    task automatic t_wb_write;
        access("R4 E->M", 1, 0, WB, E, 0, M, K_NONE, 0);
        access("R4 M->M", 1, 1, WB, M, 0, M, K_NONE, 0);
        access("R4 I->M", 1, 0, WB, I, 1, M, K_RL, 0);
    endtask

    task automatic t_ownership;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_level = 1'b0;
        req_mtype = WB; req_state = S; snoop_shared = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R5 own req", bus_req, 1);
        chk("R5 own kind", bus_kind, K_OWN);
        chk("R5 busy", busy, 1);
        chk("R5 no rsp", rsp_valid, 0);
        // request while busy must be dropped
        req_valid = 1'b1; req_write = 1'b0; req_mtype = UC; req_state = E;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R5 single pulse", bus_req, 0);
        chk("R9 busy drop rsp", rsp_valid, 0);
        chk("R9 busy drop kind", bus_kind, K_NONE);
        chk("R5 still busy", busy, 1);
        own_grant = 1'b1;
        @(negedge clk);
        own_grant = 1'b0;
        chk("R5 done valid", rsp_valid, 1);
        chk("R5 done state", rsp_state, M);
        chk("R5 done inval", rsp_inval, 0);
        chk("R5 done busy", busy, 0);
        chk("R5 done req", bus_req, 0);
        @(negedge clk);
        chk("R5 one rsp", rsp_valid, 0);
    endtask

    task automatic t_grant_idle;
        @(negedge clk);
        own_grant = 1'b1;
        @(negedge clk);
        chk("R9 idle grant rsp", rsp_valid, 0);
        chk("R9 idle grant busy", busy, 0);
        own_grant = 1'b0;
    endtask

    task automatic t_wt_write;
        access("R6 wt L1 hit", 1, 0, WT, E, 0, E, K_WP, 0);
        access("R6 wt L2 hit", 1, 1, WT, S, 0, I, K_WP, 1);
        access("R6 wt miss",   1, 1, WT, I, 0, I, K_WP, 0);
    endtask

    task automatic t_wp_write;
        access("R7 wp L1 hit", 1, 0, WP, S, 0, S, K_WP, 0);
        access("R7 wp L2 hit", 1, 1, WP, E, 0, I, K_WP, 1);
        access("R7 wp miss",   1, 0, WP, I, 1, I, K_WP, 0);
    endtask

    task automatic t_uc;
        access("R8 uc rd hit L1", 0, 0, UC, E, 0, I, K_RP, 1);
        access("R8 uc wr hit L2", 1, 1, UC, M, 0, I, K_WP, 1);
        access("R8 uc rd miss",   0, 1, UC, I, 1, I, K_RP, 0);
        access("R8 uc wr miss",   1, 0, UC, I, 0, I, K_WP, 0);
    endtask

    task automatic t_quiet;
        @(negedge clk);
        chk("R10 quiet req", bus_req, 0);
        chk("R10 quiet kind", bus_kind, K_NONE);
        chk("R10 quiet inval", rsp_inval, 0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                t_reset();
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_read_hits();
                t_read_miss();
                t_wb_write();
                t_ownership();
                t_grant_idle();
                t_wt_write();
                t_wp_write();
                t_uc();
                t_quiet();
            end
            begin
                repeat (20000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog expired actual=1 expected=0");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule